// File: doc/BRIEF.md
# Banked Cache Request Scheduler

This block is the front end of a multi-bank cache. Core requests arrive on several input ports. Each address is split into a word offset, a bank number, a set index and a tag. Each cycle, every bank assembles exactly one active request and hands it to the tag stage on the next clock edge.

An active request can come from three sources:
- a replay offered by the miss-tracking unit (the MSHR), which always wins;
- otherwise, the oldest entry of the bank's stall queue, but only while the MSHR reports room;
- new core traffic.

Core requests aimed at the same bank are folded into the active request when they agree with it on direction, set and tag and their port slot is still free. Any request that cannot be folded in is parked in the bank's stall queue.

Each bank owns a stall queue that can take several entries in one cycle. A core port stops accepting requests when the queue of the bank its current address maps to might not hold a full cycle's worth of pushes.

Top module: `bank_req_sched`

## Requirements
- R1: An address is decoded from bit 0 upward into word offset (WORD_BITS), bank select (BANK_BITS), set index (SET_BITS) and tag (the remaining bits). A field of zero width reads as 0. With the default parameters: word = addr[1:0], bank = addr[2], set = addr[4:3], tag = addr[11:5].
- R2: A request from input i occupies slot i mod PORTS_PER_BANK of the bank request. The slot carries the input index, word offset and request id.
- R3: When a bank's replay input is valid, replayTake is high in the same cycle and the next active request of that bank is the replay (actReplay = 1), with all its fields copied.
- R4: With no replay, the stall-queue head becomes the active request only while that bank's mshrFull is low. Otherwise the head stays queued.
- R5: A new core request is sent to the stall queue whenever the bank's mshrFull is high or the request being built this cycle is a replay.
- R6: A new request that differs from the request being built in write flag, set or tag, or whose slot is already taken, is pushed to the stall queue and later leaves it in arrival order.
- R7: A compatible request fills its slot in the request being built. If no request is being built, it starts one with its own write flag, set and tag.
- R8: Within one cycle, core inputs are considered in ascending index order, so the lower index claims a shared slot first.
- R9: coreReady[i] is high exactly when the stall queue of the bank addressed by coreAddr of port i has at least NUM_PORTS free entries.
- R10: After reset, no bank holds an active request, all stall queues are empty and every core port is ready.
- R11: An active request is shown for exactly one cycle. A cycle with no source leaves actValid low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coreValid | input | NUM_PORTS | Core request valid per port |
| coreReady | output | NUM_PORTS | Core request accepted per port |
| coreWrite | input | NUM_PORTS | Write flag per port |
| coreAddr | input | NUM_PORTS*ADDR_W | Word address per port |
| coreTid | input | NUM_PORTS*TID_W | Request id per port |
| mshrFull | input | NUM_BANKS | MSHR full flag per bank |
| replayValid | input | NUM_BANKS | Replay offered per bank |
| replayTake | output | NUM_BANKS | Replay consumed per bank |
| replayWrite | input | NUM_BANKS | Replay write flag |
| replaySet | input | NUM_BANKS*SET_W | Replay set index |
| replayTag | input | NUM_BANKS*TAG_W | Replay tag |
| replaySlotValid | input | NUM_BANKS*PORTS_PER_BANK | Replay slot occupancy |
| replaySlotSrc | input | NUM_BANKS*PORTS_PER_BANK*SRC_W | Replay slot input index |
| replaySlotWord | input | NUM_BANKS*PORTS_PER_BANK*WORD_W | Replay slot word offset |
| replaySlotTid | input | NUM_BANKS*PORTS_PER_BANK*TID_W | Replay slot request id |
| actValid | output | NUM_BANKS | Active request present |
| actReplay | output | NUM_BANKS | Active request is a replay |
| actWrite | output | NUM_BANKS | Active write flag |
| actSet | output | NUM_BANKS*SET_W | Active set index |
| actTag | output | NUM_BANKS*TAG_W | Active tag |
| actSlotValid | output | NUM_BANKS*PORTS_PER_BANK | Active slot occupancy |
| actSlotSrc | output | NUM_BANKS*PORTS_PER_BANK*SRC_W | Active slot input index |
| actSlotWord | output | NUM_BANKS*PORTS_PER_BANK*WORD_W | Active slot word offset |
| actSlotTid | output | NUM_BANKS*PORTS_PER_BANK*TID_W | Active slot request id |

## Verification
Two kinds of result have different timing:
- coreReady and replayTake are combinational. They are sampled 1 ns after inputs are driven on the falling edge, before any state changes.
- Every active-request field passes through one register. It is compared at the following falling edge against a bench model that uses the same stimulus.

A stalled request needs at least one more cycle. It reaches the outputs on the falling edge after the cycle in which the queue head is taken, so directed sequences hold mshrFull or a replay for a known number of cycles and then check the drained entry at that exact edge. Both the directed sequences and a long sweep over a small set and tag space compare every field against the model at these fixed sample points.

// File: rtl/bank_req_sched_pkg.sv
package bank_req_sched_pkg;
  // Strobes from a bank's control logic to its queue datapath.
  typedef struct packed {
    logic takeReplay;
    logic takeStall;
  } schedStrobes_t;
endpackage

// File: rtl/sched_addr_split.sv
module sched_addr_split #(
  parameter int ADDR_W    = 12,
  parameter int WORD_BITS = 2,
  parameter int BANK_BITS = 1,
  parameter int SET_BITS  = 2,
  localparam int TAG_BITS = ADDR_W - WORD_BITS - BANK_BITS - SET_BITS,
  localparam int WORD_W   = (WORD_BITS > 0) ? WORD_BITS : 1,
  localparam int BANK_W   = (BANK_BITS > 0) ? BANK_BITS : 1,
  localparam int SET_W    = (SET_BITS > 0) ? SET_BITS : 1,
  localparam int TAG_W    = (TAG_BITS > 0) ? TAG_BITS : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] word,
  output logic [BANK_W-1:0] bank,
  output logic [SET_W-1:0]  set,
  output logic [TAG_W-1:0]  tag
);
  // Fields sit from bit 0 upward: word, bank, set, tag; an empty one reads 0.
  if (WORD_BITS > 0) begin : g_word
    assign word = addr[WORD_BITS-1:0];
  end else begin : g_noWord
    assign word = '0;
  end
  if (BANK_BITS > 0) begin : g_bank
    assign bank = addr[WORD_BITS +: BANK_BITS];
  end else begin : g_noBank
    assign bank = '0;
  end
  if (SET_BITS > 0) begin : g_set
    assign set = addr[WORD_BITS + BANK_BITS +: SET_BITS];
  end else begin : g_noSet
    assign set = '0;
  end
  if (TAG_BITS > 0) begin : g_tag
    assign tag = addr[ADDR_W-1 -: TAG_BITS];
  end else begin : g_noTag
    assign tag = '0;
  end
endmodule

// File: rtl/sched_stall_fifo.sv
module sched_stall_fifo #(
  parameter int DEPTH_BITS = 3,
  parameter int EW         = 16,
  parameter int NPUSH      = 4,
  localparam int DEPTH     = 1 << DEPTH_BITS,
  localparam int CNT_W     = DEPTH_BITS + 1,
  localparam int PC_W      = $clog2(NPUSH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NPUSH-1:0]      pushMask,
  input  logic [NPUSH*EW-1:0]   pushData,
  input  logic                  pop,
  output logic                  headValid,
  output logic [EW-1:0]         headData,
  output logic [CNT_W-1:0]      freeCount
);
  logic [EW-1:0]         mem [DEPTH];
  logic [DEPTH_BITS-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0]      count;
  logic [DEPTH_BITS-1:0] wrIdx [NPUSH];
  logic [PC_W-1:0]       pushTotal;

  // Pushes are packed in ascending port order behind the current tail.
  always_comb begin
    pushTotal = '0;
    for (int i = 0; i < NPUSH; i++) begin
      wrIdx[i] = wrPtr + DEPTH_BITS'(pushTotal);
      if (pushMask[i]) pushTotal = pushTotal + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      for (int i = 0; i < NPUSH; i++) begin
        if (pushMask[i]) mem[wrIdx[i]] <= pushData[i*EW +: EW];
      end
      rdPtr <= rdPtr + DEPTH_BITS'(pop);
      wrPtr <= wrPtr + DEPTH_BITS'(pushTotal);
      count <= count + CNT_W'(pushTotal) - CNT_W'(pop);
    end
  end

  assign headValid = (count != '0);
  assign headData  = mem[rdPtr];
  assign freeCount = CNT_W'(DEPTH) - count;

  // R9: the readiness rule must keep the queue from overflowing.
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, CNT_W'(pushTotal)} <= ({1'b0, freeCount} + (CNT_W+1)'(pop))));
  // R4: the head is only taken when there is one.
  a_r4_pop_has_data: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
endmodule

// File: rtl/sched_bank_ctrl.sv
module sched_bank_ctrl
  import bank_req_sched_pkg::*;
#(
  parameter int NP      = 4,
  parameter int PPB     = 2,
  parameter int BANK_W  = 1,
  parameter int BANK_ID = 0,
  parameter int SET_W   = 2,
  parameter int TAG_W   = 7,
  parameter int WORD_W  = 2,
  parameter int SRC_W   = 2,
  parameter int TID_W   = 4,
  localparam int SRC_LO  = TID_W,
  localparam int WORD_LO = SRC_LO + SRC_W,
  localparam int TAG_LO  = WORD_LO + WORD_W,
  localparam int SET_LO  = TAG_LO + TAG_W,
  localparam int WR_BIT  = SET_LO + SET_W,
  localparam int EW      = WR_BIT + 1
) (
  input  logic [NP-1:0]         coreFire,
  input  logic [NP*BANK_W-1:0]  coreBank,
  input  logic [NP*EW-1:0]      portEntry,
  input  logic                  mshrFull,
  input  logic                  replayValid,
  input  logic                  replayWrite,
  input  logic [SET_W-1:0]      replaySet,
  input  logic [TAG_W-1:0]      replayTag,
  input  logic [PPB-1:0]        replaySlotValid,
  input  logic [PPB*SRC_W-1:0]  replaySlotSrc,
  input  logic [PPB*WORD_W-1:0] replaySlotWord,
  input  logic [PPB*TID_W-1:0]  replaySlotTid,
  input  logic                  headValid,
  input  logic [EW-1:0]         headData,
  output schedStrobes_t         strobes,
  output logic [NP-1:0]         pushMask,
  output logic                  nValid,
  output logic                  nReplay,
  output logic                  nWrite,
  output logic [SET_W-1:0]      nSet,
  output logic [TAG_W-1:0]      nTag,
  output logic [PPB-1:0]        nSlotValid,
  output logic [PPB*SRC_W-1:0]  nSlotSrc,
  output logic [PPB*WORD_W-1:0] nSlotWord,
  output logic [PPB*TID_W-1:0]  nSlotTid
);
  logic [EW-1:0] ent;
  int            slot;
  logic          clash;

  always_comb begin
    strobes    = '0;
    pushMask   = '0;
    nValid     = 1'b0;
    nReplay    = 1'b0;
    nWrite     = 1'b0;
    nSet       = '0;
    nTag       = '0;
    nSlotValid = '0;
    nSlotSrc   = '0;
    nSlotWord  = '0;
    nSlotTid   = '0;
    ent        = '0;
    slot       = 0;
    clash      = 1'b0;
    // Source ranking: replay, then stall head (MSHR has room), then core.
    if (replayValid) begin
      strobes.takeReplay = 1'b1;
      nValid     = 1'b1;
      nReplay    = 1'b1;
      nWrite     = replayWrite;
      nSet       = replaySet;
      nTag       = replayTag;
      nSlotValid = replaySlotValid;
      nSlotSrc   = replaySlotSrc;
      nSlotWord  = replaySlotWord;
      nSlotTid   = replaySlotTid;
    end else if (headValid && !mshrFull) begin
      strobes.takeStall = 1'b1;
      nValid = 1'b1;
      nWrite = headData[WR_BIT];
      nSet   = headData[SET_LO +: SET_W];
      nTag   = headData[TAG_LO +: TAG_W];
      slot   = int'(headData[SRC_LO +: SRC_W]) % PPB;
      nSlotValid[slot]               = 1'b1;
      nSlotSrc[slot*SRC_W +: SRC_W]  = headData[SRC_LO +: SRC_W];
      nSlotWord[slot*WORD_W +: WORD_W] = headData[WORD_LO +: WORD_W];
      nSlotTid[slot*TID_W +: TID_W]  = headData[TID_W-1:0];
    end
    // Core inputs in ascending index order.
    for (int i = 0; i < NP; i++) begin
      if (coreFire[i] && (coreBank[i*BANK_W +: BANK_W] == BANK_W'(BANK_ID))) begin
        ent   = portEntry[i*EW +: EW];
        slot  = i % PPB;
        clash = mshrFull || (nValid && (nReplay || (nWrite != ent[WR_BIT]) ||
                (nSet != ent[SET_LO +: SET_W]) || (nTag != ent[TAG_LO +: TAG_W]) ||
                nSlotValid[slot]));
        if (clash) begin
          pushMask[i] = 1'b1;
        end else begin
          if (!nValid) begin
            nValid = 1'b1;
            nWrite = ent[WR_BIT];
            nSet   = ent[SET_LO +: SET_W];
            nTag   = ent[TAG_LO +: TAG_W];
          end
          nSlotValid[slot]                 = 1'b1;
          nSlotSrc[slot*SRC_W +: SRC_W]    = ent[SRC_LO +: SRC_W];
          nSlotWord[slot*WORD_W +: WORD_W] = ent[WORD_LO +: WORD_W];
          nSlotTid[slot*TID_W +: TID_W]    = ent[TID_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/bank_req_sched.sv
module bank_req_sched
  import bank_req_sched_pkg::*;
#(
  parameter int NUM_PORTS      = 4,
  parameter int BANK_BITS      = 1,
  parameter int PORTS_PER_BANK = 2,
  parameter int ADDR_W         = 12,
  parameter int WORD_BITS      = 2,
  parameter int SET_BITS       = 2,
  parameter int TID_W          = 4,
  parameter int STALL_BITS     = 3,
  localparam int NUM_BANKS = 1 << BANK_BITS,
  localparam int TAG_BITS  = ADDR_W - WORD_BITS - BANK_BITS - SET_BITS,
  localparam int WORD_W    = (WORD_BITS > 0) ? WORD_BITS : 1,
  localparam int BANK_W    = (BANK_BITS > 0) ? BANK_BITS : 1,
  localparam int SET_W     = (SET_BITS > 0) ? SET_BITS : 1,
  localparam int TAG_W     = (TAG_BITS > 0) ? TAG_BITS : 1,
  localparam int SRC_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int NB        = NUM_BANKS,
  localparam int PPB       = PORTS_PER_BANK
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS-1:0]        coreValid,
  output logic [NUM_PORTS-1:0]        coreReady,
  input  logic [NUM_PORTS-1:0]        coreWrite,
  input  logic [NUM_PORTS*ADDR_W-1:0] coreAddr,
  input  logic [NUM_PORTS*TID_W-1:0]  coreTid,
  input  logic [NB-1:0]               mshrFull,
  input  logic [NB-1:0]               replayValid,
  output logic [NB-1:0]               replayTake,
  input  logic [NB-1:0]               replayWrite,
  input  logic [NB*SET_W-1:0]         replaySet,
  input  logic [NB*TAG_W-1:0]         replayTag,
  input  logic [NB*PPB-1:0]           replaySlotValid,
  input  logic [NB*PPB*SRC_W-1:0]     replaySlotSrc,
  input  logic [NB*PPB*WORD_W-1:0]    replaySlotWord,
  input  logic [NB*PPB*TID_W-1:0]     replaySlotTid,
  output logic [NB-1:0]               actValid,
  output logic [NB-1:0]               actReplay,
  output logic [NB-1:0]               actWrite,
  output logic [NB*SET_W-1:0]         actSet,
  output logic [NB*TAG_W-1:0]         actTag,
  output logic [NB*PPB-1:0]           actSlotValid,
  output logic [NB*PPB*SRC_W-1:0]     actSlotSrc,
  output logic [NB*PPB*WORD_W-1:0]    actSlotWord,
  output logic [NB*PPB*TID_W-1:0]     actSlotTid
);
  localparam int EW    = 1 + SET_W + TAG_W + WORD_W + SRC_W + TID_W;
  localparam int CNT_W = STALL_BITS + 1;

  logic [WORD_W-1:0] portWord [NUM_PORTS];
  logic [BANK_W-1:0] portBank [NUM_PORTS];
  logic [SET_W-1:0]  portSet  [NUM_PORTS];
  logic [TAG_W-1:0]  portTag  [NUM_PORTS];
  logic [NUM_PORTS*EW-1:0]     portEntry;
  logic [NUM_PORTS*BANK_W-1:0] portBankFlat;
  logic [NUM_PORTS-1:0]        coreFire;

  // Per-bank control outputs and datapath state.
  schedStrobes_t         strb     [NB];
  logic [NUM_PORTS-1:0]  pushMask [NB];
  logic [NUM_PORTS-1:0]  fireHere [NB];
  logic                  headValid[NB];
  logic [EW-1:0]         headData [NB];
  logic [CNT_W-1:0]      freeCnt  [NB];
  logic                  nValid[NB], nReplay[NB], nWrite[NB];
  logic [SET_W-1:0]      nSet [NB];
  logic [TAG_W-1:0]      nTag [NB];
  logic [PPB-1:0]        nSv  [NB];
  logic [PPB*SRC_W-1:0]  nSrc [NB];
  logic [PPB*WORD_W-1:0] nWord[NB];
  logic [PPB*TID_W-1:0]  nTid [NB];
  logic                  validQ[NB], replayQ[NB], writeQ[NB];
  logic [SET_W-1:0]      setQ [NB];
  logic [TAG_W-1:0]      tagQ [NB];
  logic [PPB-1:0]        svQ  [NB];
  logic [PPB*SRC_W-1:0]  srcQ [NB];
  logic [PPB*WORD_W-1:0] wordQ[NB];
  logic [PPB*TID_W-1:0]  tidQ [NB];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    sched_addr_split #(
      .ADDR_W(ADDR_W), .WORD_BITS(WORD_BITS), .BANK_BITS(BANK_BITS), .SET_BITS(SET_BITS)
    ) u_split (
      .addr(coreAddr[p*ADDR_W +: ADDR_W]),
      .word(portWord[p]), .bank(portBank[p]), .set(portSet[p]), .tag(portTag[p])
    );
  end

  // Entry layout, LSB first: tid, src, word, tag, set, write.
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      portEntry[p*EW +: EW] = {coreWrite[p], portSet[p], portTag[p], portWord[p],
                               SRC_W'(p), coreTid[p*TID_W +: TID_W]};
      portBankFlat[p*BANK_W +: BANK_W] = portBank[p];
      coreReady[p] = (freeCnt[portBank[p]] >= CNT_W'(NUM_PORTS));
    end
  end
  assign coreFire = coreValid & coreReady;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sched_bank_ctrl #(
      .NP(NUM_PORTS), .PPB(PPB), .BANK_W(BANK_W), .BANK_ID(b), .SET_W(SET_W),
      .TAG_W(TAG_W), .WORD_W(WORD_W), .SRC_W(SRC_W), .TID_W(TID_W)
    ) u_ctrl (
      .coreFire(coreFire), .coreBank(portBankFlat), .portEntry(portEntry),
      .mshrFull(mshrFull[b]), .replayValid(replayValid[b]), .replayWrite(replayWrite[b]),
      .replaySet(replaySet[b*SET_W +: SET_W]), .replayTag(replayTag[b*TAG_W +: TAG_W]),
      .replaySlotValid(replaySlotValid[b*PPB +: PPB]),
      .replaySlotSrc(replaySlotSrc[b*PPB*SRC_W +: PPB*SRC_W]),
      .replaySlotWord(replaySlotWord[b*PPB*WORD_W +: PPB*WORD_W]),
      .replaySlotTid(replaySlotTid[b*PPB*TID_W +: PPB*TID_W]),
      .headValid(headValid[b]), .headData(headData[b]),
      .strobes(strb[b]), .pushMask(pushMask[b]),
      .nValid(nValid[b]), .nReplay(nReplay[b]), .nWrite(nWrite[b]), .nSet(nSet[b]),
      .nTag(nTag[b]), .nSlotValid(nSv[b]), .nSlotSrc(nSrc[b]), .nSlotWord(nWord[b]),
      .nSlotTid(nTid[b])
    );

    sched_stall_fifo #(.DEPTH_BITS(STALL_BITS), .EW(EW), .NPUSH(NUM_PORTS)) u_stall (
      .clk(clk), .rst(rst), .pushMask(pushMask[b]), .pushData(portEntry),
      .pop(strb[b].takeStall), .headValid(headValid[b]), .headData(headData[b]),
      .freeCount(freeCnt[b])
    );

    always_ff @(posedge clk) begin
      if (rst) validQ[b] <= 1'b0;
      else     validQ[b] <= nValid[b];
      replayQ[b] <= nReplay[b];
      writeQ[b]  <= nWrite[b];
      setQ[b]    <= nSet[b];
      tagQ[b]    <= nTag[b];
      svQ[b]     <= nSv[b];
      srcQ[b]    <= nSrc[b];
      wordQ[b]   <= nWord[b];
      tidQ[b]    <= nTid[b];
    end

    always_comb begin
      for (int p = 0; p < NUM_PORTS; p++)
        fireHere[b][p] = coreFire[p] && (portBank[p] == BANK_W'(b));
    end

    // R3: an offered replay is the next active request.
    a_r3_replay_first: assert property (@(posedge clk) disable iff (rst)
      replayValid[b] |=> (validQ[b] && replayQ[b]));
    // R5: nothing merges into a replay; every accepted request is queued.
    a_r5_replay_blocks_merge: assert property (@(posedge clk) disable iff (rst)
      replayValid[b] |-> (pushMask[b] == fireHere[b]));
    // R4: a full MSHR keeps the stall head in place.
    a_r4_full_holds_stall: assert property (@(posedge clk) disable iff (rst)
      mshrFull[b] |-> !strb[b].takeStall);
    // R5: while the MSHR is full, no core request reaches the active slots.
    a_r5_full_queues_all: assert property (@(posedge clk) disable iff (rst)
      (mshrFull[b] && !replayValid[b]) |=> !validQ[b]);
    // R7: a non-replay active request always carries at least one slot.
    a_r7_active_has_slot: assert property (@(posedge clk) disable iff (rst)
      (validQ[b] && !replayQ[b]) |-> (svQ[b] != '0));
  end

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      replayTake[b] = strb[b].takeReplay;
      actValid[b]   = validQ[b];
      actReplay[b]  = replayQ[b];
      actWrite[b]   = writeQ[b];
      actSet[b*SET_W +: SET_W] = setQ[b];
      actTag[b*TAG_W +: TAG_W] = tagQ[b];
      actSlotValid[b*PPB +: PPB]               = svQ[b];
      actSlotSrc[b*PPB*SRC_W +: PPB*SRC_W]     = srcQ[b];
      actSlotWord[b*PPB*WORD_W +: PPB*WORD_W]  = wordQ[b];
      actSlotTid[b*PPB*TID_W +: PPB*TID_W]     = tidQ[b];
    end
  end
endmodule

// File: tb/bank_req_sched_bench.sv
`timescale 1ns/100ps
module bank_req_sched_bench;
  localparam int NP = 4, NB = 2, PPB = 2, AW = 12, SW = 2, TW = 7, WW = 2, RW = 2, IW = 4;
  localparam int DEPTH = 8;

  logic clk = 0, rst = 1;
  always #2.5 clk = ~clk;

  logic [NP-1:0] coreValid, coreReady, coreWrite;
  logic [NP*AW-1:0] coreAddr;
  logic [NP*IW-1:0] coreTid;
  logic [NB-1:0] mshrFull, replayValid, replayTake, replayWrite;
  logic [NB*SW-1:0] replaySet;
  logic [NB*TW-1:0] replayTag;
  logic [NB*PPB-1:0] replaySlotValid;
  logic [NB*PPB*RW-1:0] replaySlotSrc;
  logic [NB*PPB*WW-1:0] replaySlotWord;
  logic [NB*PPB*IW-1:0] replaySlotTid;
  logic [NB-1:0] actValid, actReplay, actWrite;
  logic [NB*SW-1:0] actSet;
  logic [NB*TW-1:0] actTag;
  logic [NB*PPB-1:0] actSlotValid;
  logic [NB*PPB*RW-1:0] actSlotSrc;
  logic [NB*PPB*WW-1:0] actSlotWord;
  logic [NB*PPB*IW-1:0] actSlotTid;

  bank_req_sched u_bank_req_sched (
    .clk(clk), .rst(rst), .coreValid(coreValid), .coreReady(coreReady),
    .coreWrite(coreWrite), .coreAddr(coreAddr), .coreTid(coreTid), .mshrFull(mshrFull),
    .replayValid(replayValid), .replayTake(replayTake), .replayWrite(replayWrite),
    .replaySet(replaySet), .replayTag(replayTag), .replaySlotValid(replaySlotValid),
    .replaySlotSrc(replaySlotSrc), .replaySlotWord(replaySlotWord),
    .replaySlotTid(replaySlotTid), .actValid(actValid), .actReplay(actReplay),
    .actWrite(actWrite), .actSet(actSet), .actTag(actTag), .actSlotValid(actSlotValid),
    .actSlotSrc(actSlotSrc), .actSlotWord(actSlotWord), .actSlotTid(actSlotTid)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model state.
  typedef struct { int w; int set; int tag; int word; int src; int tid; } ent_t;
  ent_t q [NB][$];
  int eV[NB], eR[NB], eW[NB], eSet[NB], eTag[NB];
  int eSV[NB][PPB], eSrc[NB][PPB], eWord[NB][PPB], eTid[NB][PPB];

  function automatic int bankOf(int a); return (a >> 2) & 1; endfunction

  task automatic clearIn();
    coreValid = '0; coreWrite = '0; coreAddr = '0; coreTid = '0;
    mshrFull = '0; replayValid = '0; replayWrite = '0; replaySet = '0; replayTag = '0;
    replaySlotValid = '0; replaySlotSrc = '0; replaySlotWord = '0; replaySlotTid = '0;
  endtask

  task automatic setCore(int i, bit w, int a, int tid);
    coreValid[i] = 1'b1;
    coreWrite[i] = w;
    coreAddr[i*AW +: AW] = AW'(a);
    coreTid[i*IW +: IW] = IW'(tid);
  endtask

  function automatic int mkAddr(int word, int bank, int set, int tag);
    return word | (bank << 2) | (set << 3) | (tag << 5);
  endfunction

  task automatic cycle();
    bit fire [NP];
    #1;
    for (int i = 0; i < NP; i++) begin
      int a = int'(coreAddr[i*AW +: AW]);
      bit rdy = ((DEPTH - q[bankOf(a)].size()) >= NP);
      chk("R9", "coreReady", coreReady[i], rdy);
      fire[i] = coreValid[i] && rdy;
    end
    for (int b = 0; b < NB; b++) begin
      chk("R3", "replayTake", replayTake[b], replayValid[b]);
      eV[b] = 0; eR[b] = 0; eW[b] = 0; eSet[b] = 0; eTag[b] = 0;
      for (int s = 0; s < PPB; s++) eSV[b][s] = 0;
      if (replayValid[b]) begin
        eV[b] = 1; eR[b] = 1; eW[b] = replayWrite[b];
        eSet[b] = int'(replaySet[b*SW +: SW]); eTag[b] = int'(replayTag[b*TW +: TW]);
        for (int s = 0; s < PPB; s++) begin
          eSV[b][s]   = replaySlotValid[b*PPB + s];
          eSrc[b][s]  = int'(replaySlotSrc[(b*PPB+s)*RW +: RW]);
          eWord[b][s] = int'(replaySlotWord[(b*PPB+s)*WW +: WW]);
          eTid[b][s]  = int'(replaySlotTid[(b*PPB+s)*IW +: IW]);
        end
      end else if (q[b].size() > 0 && !mshrFull[b]) begin
        ent_t e = q[b].pop_front();
        int s = e.src % PPB;
        eV[b] = 1; eW[b] = e.w; eSet[b] = e.set; eTag[b] = e.tag;
        eSV[b][s] = 1; eSrc[b][s] = e.src; eWord[b][s] = e.word; eTid[b][s] = e.tid;
      end
      for (int i = 0; i < NP; i++) begin
        int a = int'(coreAddr[i*AW +: AW]);
        if (fire[i] && bankOf(a) == b) begin
          ent_t e;
          int s = i % PPB;
          e.w = coreWrite[i]; e.set = (a >> 3) & 3; e.tag = (a >> 5) & 127;
          e.word = a & 3; e.src = i; e.tid = int'(coreTid[i*IW +: IW]);
          if (mshrFull[b] || (eV[b] != 0 && (eR[b] != 0 || eW[b] != e.w ||
              eSet[b] != e.set || eTag[b] != e.tag || eSV[b][s] != 0)))
            q[b].push_back(e);
          else begin
            if (eV[b] == 0) begin
              eV[b] = 1; eW[b] = e.w; eSet[b] = e.set; eTag[b] = e.tag;
            end
            eSV[b][s] = 1; eSrc[b][s] = i; eWord[b][s] = e.word; eTid[b][s] = e.tid;
          end
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      chk("R7", "actValid", actValid[b], eV[b]);
      if (eV[b] != 0) begin
        chk("R3", "actReplay", actReplay[b], eR[b]);
        chk("R6", "actWrite", actWrite[b], eW[b]);
        chk("R1", "actSet", actSet[b*SW +: SW], eSet[b]);
        chk("R1", "actTag", actTag[b*TW +: TW], eTag[b]);
        for (int s = 0; s < PPB; s++) begin
          chk("R6", "slotValid", actSlotValid[b*PPB + s], eSV[b][s]);
          if (eSV[b][s] != 0) begin
            chk("R2", "slotSrc", actSlotSrc[(b*PPB+s)*RW +: RW], eSrc[b][s]);
            chk("R1", "slotWord", actSlotWord[(b*PPB+s)*WW +: WW], eWord[b][s]);
            chk("R7", "slotTid", actSlotTid[(b*PPB+s)*IW +: IW], eTid[b][s]);
          end
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R11 watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clearIn();
    repeat (4) @(negedge clk);
    rst = 0;
    // R10: reset state.
    #1;
    chk("R10", "actValid", actValid, 0);
    chk("R10", "coreReady", coreReady, 4'hF);
    cycle();

    // R8: inputs 0 and 2 share slot 0; input 0 wins, input 2 drains next.
    clearIn();
    setCore(0, 0, mkAddr(1, 0, 1, 5), 3);
    setCore(2, 0, mkAddr(2, 0, 1, 5), 7);
    cycle();
    chk("R8", "slot0 src", actSlotSrc[1:0], 0);
    clearIn();
    cycle();
    chk("R8", "drained src", actSlotSrc[1:0], 2);

    // R7: inputs 0 and 1 merge into one bank-1 request.
    clearIn();
    setCore(0, 1, mkAddr(0, 1, 2, 9), 1);
    setCore(1, 1, mkAddr(3, 1, 2, 9), 2);
    cycle();
    chk("R7", "merged slots", actSlotValid[3:2], 3);

    // R6: write flags differ, input 1 is queued.
    clearIn();
    setCore(0, 1, mkAddr(0, 0, 3, 4), 5);
    setCore(1, 0, mkAddr(0, 0, 3, 4), 6);
    cycle();
    chk("R6", "only slot0", actSlotValid[1:0], 1);
    clearIn();
    cycle();
    chk("R6", "drained src", actSlotSrc[3:2], 1);

    // R5: replay blocks a compatible core request.
    clearIn();
    replayValid[0] = 1; replaySet[1:0] = 2; replayTag[6:0] = 11; replaySlotValid[1:0] = 2;
    setCore(0, 0, mkAddr(0, 0, 2, 11), 4);
    cycle();
    chk("R5", "replay active", actReplay[0], 1);
    clearIn();
    cycle();
    chk("R5", "core after replay", actReplay[0], 0);
    chk("R5", "core after valid", actValid[0], 1);

    // R4: full MSHR keeps the head queued.
    clearIn();
    mshrFull[0] = 1;
    setCore(0, 0, mkAddr(2, 0, 0, 1), 9);
    cycle();
    chk("R4", "held 1", actValid[0], 0);
    coreValid = '0;
    cycle();
    chk("R4", "held 2", actValid[0], 0);
    clearIn();
    cycle();
    chk("R4", "released", actValid[0], 1);
    chk("R4", "released word", actSlotWord[1:0], 2);

    // R11: idle cycle leaves no active request.
    clearIn();
    cycle();
    chk("R11", "idle", actValid, 0);

    // R9: fill bank 0 queue until ports to it stall.
    clearIn();
    mshrFull[0] = 1;
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < NP; i++) setCore(i, 0, mkAddr(i, 0, 0, 2), i);
      cycle();
    end
    #1;
    chk("R9", "bank0 stalled", coreReady, 0);
    setCore(3, 0, mkAddr(0, 1, 0, 0), 0);
    #1;
    chk("R9", "bank1 open", coreReady[3], 1);
    cycle();
    clearIn();
    repeat (12) cycle();

    // Sweep over a small set/tag space.
    for (int n = 0; n < 4000; n++) begin
      clearIn();
      for (int i = 0; i < NP; i++) begin
        if ($urandom_range(0, 1)) setCore(i, 1'($urandom_range(0, 1)),
            mkAddr($urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1),
                   $urandom_range(0, 1)), $urandom_range(0, 15));
      end
      for (int b = 0; b < NB; b++) begin
        mshrFull[b] = ($urandom_range(0, 3) == 0);
        if ($urandom_range(0, 6) == 0) begin
          replayValid[b] = 1; replayWrite[b] = 1'($urandom_range(0, 1));
          replaySet[b*SW +: SW] = SW'($urandom_range(0, 3));
          replayTag[b*TW +: TW] = TW'($urandom_range(0, 127));
          replaySlotValid[b*PPB +: PPB] = PPB'($urandom_range(1, 3));
          replaySlotSrc[b*PPB*RW +: PPB*RW] = 4'($urandom_range(0, 15));
          replaySlotWord[b*PPB*WW +: PPB*WW] = 4'($urandom_range(0, 15));
          replaySlotTid[b*PPB*IW +: PPB*IW] = 8'($urandom_range(0, 255));
        end
      end
      cycle();
    end
    clearIn();
    repeat (20) cycle();
    chk("R11", "final idle", actValid, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule